// File: doc/BRIEF.md
# SDRAM Command Sequencer with Power-Up Initialization

This block produces the command stream for a single-rank SDRAM. It drives chip select, row strobe, column strobe, write enable, the internal bank select and the shared row/column address bus. After reset it stays quiet until power-up has been enabled and the host presents its first access. It then performs the initialization walk: a precharge of all banks, eight auto-refresh commands and one mode-register load. A configuration bit sets the order of the mode-register load and the refreshes.

Once initialized, it serves read and write requests from a request/acknowledge host port. It remembers the single row that is open. On a request to that row it goes straight to the column command. A request to any other row first closes the open row and then activates the new one. Only one row in one bank is ever open.

All command outputs are registered. Gaps between commands are set by parameters: precharge time, refresh cycle time and activate-to-column delay. The gap after a mode-register load is fixed at two cycles.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is held and right after it, the command pins show NOP, `req_ack` is 0 and `init_done` is 0. Commands are encoded {cs_n,ras_n,cas_n,we_n}: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode load 0000.
- R2: No command other than NOP is issued before power-up starts. Power-up starts only when `cfg_pu_arm` is 1 and `req_valid` is 1 in the same cycle.
- R3: With `cfg_pu_order`=0 the sequence is precharge-all, T_RP NOPs, then eight refreshes each followed by T_RFC NOPs, then the mode load.
- R4: With `cfg_pu_order`=1 the sequence is precharge-all, T_RP NOPs, the mode load, then the eight refreshes each followed by T_RFC NOPs.
- R5: The mode load drives `sd_a[6:4]` with `cfg_cas_lat`. All other address bits are 0, which gives burst length 1 and sequential wrap, and `sd_ba` is 0.
- R6: The two cycles after a mode load are NOPs, and the next command appears in the third cycle.
- R7: A read or write puts the column on `sd_a[COL_W-1:0]` and the bank on `sd_ba`, with `sd_a[10]` and all higher bits at 0. `req_ack` is 1 for exactly that cycle, and in no other cycle.
- R8: A request to a row other than the open one gives a precharge with `sd_a[10]`=1 (all banks). After T_RP NOPs comes an activate with the new bank on `sd_ba` and the row on `sd_a`. After T_RCD NOPs comes the column command.
- R9: When no row is open, a request goes straight to activate, then T_RCD NOPs, then the column command. A request to the open row goes straight to the column command.
- R10: `req_ack` stays 0 until `init_done` is 1. `init_done` rises with the last command of the power-up walk and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pu_arm | input | 1 | Power-up enable; the walk starts on the next access |
| cfg_pu_order | input | 1 | 0: refreshes before mode load; 1: mode load first |
| cfg_cas_lat | input | 3 | CAS latency placed in the mode word |
| req_valid | input | 1 | Host access request, held until acknowledged |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | BA_W+ROW_W+COL_W | {bank, row, column} |
| req_ack | output | 1 | One-cycle pulse with the column command |
| init_done | output | 1 | Power-up walk finished |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_ba | output | BA_W | SDRAM internal bank select |
| sd_a | output | ROW_W | SDRAM address bus |

## Verification
The assertions assume three things about the host:
- it holds `req_valid`, `req_write` and `req_addr` steady until it sees `req_ack`;
- it drops `req_valid` before the next clock edge;
- it does not change `cfg_pu_order` or `cfg_cas_lat` during the power-up walk.

The bench drives every input on the falling edge. A request task raises the request, waits for the acknowledge pulse and then lowers it at once. Configuration is written only while the sequencer is held in reset or is still waiting to start.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
   typedef enum logic [3:0] {
      CMD_LMR = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_ACT = 4'b0011,
      CMD_WR  = 4'b0100,
      CMD_RD  = 4'b0101,
      CMD_NOP = 4'b0111
   } sd_cmd_e;

   typedef enum logic [2:0] {
      ST_COLD,
      ST_REFS,
      ST_LMR,
      ST_READY,
      ST_ACT,
      ST_COLUMN
   } seq_state_e;
endpackage

// File: rtl/sdseq_mode_word.sv
module sdseq_mode_word #(
   parameter int A_W = 13
) (
   input  logic [2:0]     cas_lat,
   output logic [A_W-1:0] word
);
   generate
      if (A_W > 7) begin : g_pad
         assign word = {{(A_W-7){1'b0}}, cas_lat, 1'b0, 3'b000};
      end else begin : g_narrow
         $error("sdseq_mode_word: address bus narrower than mode word");
         assign word = '0;
      end
   endgenerate
endmodule

// File: rtl/sdseq_gap_timer.sv
module sdseq_gap_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy
);
   logic [CNT_W-1:0] cnt;

   assign busy = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (load)  cnt <= load_val;
      else if (busy)  cnt <= cnt - 1'b1;
   end

   // a new gap is only started once the previous one has run out
   p_load_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy);
endmodule

// File: rtl/sdseq_page_track.sv
module sdseq_page_track #(
   parameter int BA_W  = 2,
   parameter int ROW_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_fire,
   input  logic             pre_fire,
   input  logic [BA_W-1:0]  act_bank,
   input  logic [ROW_W-1:0] act_row,
   output logic             open_valid,
   output logic             hit
);
   logic [BA_W-1:0]  open_bank;
   logic [ROW_W-1:0] open_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_valid <= 1'b0;
         open_bank  <= '0;
         open_row   <= '0;
      end else if (pre_fire) begin
         open_valid <= 1'b0;
      end else if (act_fire) begin
         open_valid <= 1'b1;
         open_bank  <= act_bank;
         open_row   <= act_row;
      end
   end

   assign hit = open_valid && (open_bank == act_bank) && (open_row == act_row);

   // only one row may be open: activation needs everything closed
   p_single_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      act_fire |-> !open_valid);
   p_pre_act_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_fire && pre_fire));
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
   import sdseq_pkg::*;
#(
   parameter int BA_W  = 2,
   parameter int ROW_W = 13,
   parameter int COL_W = 9,
   parameter int T_RP  = 2,
   parameter int T_RFC = 6,
   parameter int T_RCD = 2,
   parameter int N_REF = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_pu_arm,
   input  logic                        cfg_pu_order,
   input  logic [2:0]                  cfg_cas_lat,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic [BA_W+ROW_W+COL_W-1:0] req_addr,
   output logic                        req_ack,
   output logic                        init_done,
   output logic                        sd_cs_n,
   output logic                        sd_ras_n,
   output logic                        sd_cas_n,
   output logic                        sd_we_n,
   output logic [BA_W-1:0]             sd_ba,
   output logic [ROW_W-1:0]            sd_a
);
   localparam int A_W     = ROW_W;
   localparam int LMR_GAP = 2;
   localparam int G_A     = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int G_B     = (G_A > T_RCD) ? G_A : T_RCD;
   localparam int MAXGAP  = (G_B > LMR_GAP) ? G_B : LMR_GAP;
   localparam int CNT_W   = $clog2(MAXGAP + 1);
   localparam int REF_W   = $clog2(N_REF + 1);

   generate
      if (COL_W > 10) begin : g_bad_col
         $error("sdram_cmd_seq: column must stay below address bit 10");
      end
      if (ROW_W < 11) begin : g_bad_row
         $error("sdram_cmd_seq: address bus needs bit 10");
      end
      if (N_REF < 1) begin : g_bad_ref
         $error("sdram_cmd_seq: at least one refresh required");
      end
   endgenerate

   // request fields
   logic [BA_W-1:0]  rq_bank;
   logic [ROW_W-1:0] rq_row;
   logic [COL_W-1:0] rq_col;
   assign {rq_bank, rq_row, rq_col} = req_addr;

   seq_state_e       state, nxt_state;
   sd_cmd_e          cmd_q, nxt_cmd;
   logic [BA_W-1:0]  ba_q, nxt_ba;
   logic [A_W-1:0]   a_q, nxt_a;
   logic             ack_q, nxt_ack;
   logic             pu_done, done_set;
   logic [REF_W-1:0] ref_cnt;
   logic             ref_inc, ref_clr;
   logic             t_load, t_busy;
   logic [CNT_W-1:0] t_val;
   logic             act_fire, pre_fire, open_valid, page_hit;
   logic [A_W-1:0]   mode_word;

   sdseq_mode_word #(.A_W(A_W)) u_mode (
      .cas_lat (cfg_cas_lat),
      .word    (mode_word)
   );

   sdseq_gap_timer #(.CNT_W(CNT_W)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .busy     (t_busy)
   );

   sdseq_page_track #(.BA_W(BA_W), .ROW_W(ROW_W)) u_page (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_fire   (act_fire),
      .pre_fire   (pre_fire),
      .act_bank   (rq_bank),
      .act_row    (rq_row),
      .open_valid (open_valid),
      .hit        (page_hit)
   );

   always_comb begin
      nxt_state = state;
      nxt_cmd   = CMD_NOP;
      nxt_ba    = '0;
      nxt_a     = '0;
      nxt_ack   = 1'b0;
      t_load    = 1'b0;
      t_val     = '0;
      act_fire  = 1'b0;
      pre_fire  = 1'b0;
      ref_inc   = 1'b0;
      ref_clr   = 1'b0;
      done_set  = 1'b0;
      if (!t_busy) begin
         case (state)
            ST_COLD: if (cfg_pu_arm && req_valid) begin
               nxt_cmd   = CMD_PRE;
               nxt_a[10] = 1'b1;
               pre_fire  = 1'b1;
               t_load    = 1'b1;
               t_val     = CNT_W'(T_RP);
               ref_clr   = 1'b1;
               nxt_state = cfg_pu_order ? ST_LMR : ST_REFS;
            end
            ST_REFS: begin
               nxt_cmd = CMD_REF;
               t_load  = 1'b1;
               t_val   = CNT_W'(T_RFC);
               ref_inc = 1'b1;
               if (ref_cnt == REF_W'(N_REF - 1)) begin
                  nxt_state = cfg_pu_order ? ST_READY : ST_LMR;
                  done_set  = cfg_pu_order;
               end
            end
            ST_LMR: begin
               nxt_cmd   = CMD_LMR;
               nxt_a     = mode_word;
               t_load    = 1'b1;
               t_val     = CNT_W'(LMR_GAP);
               nxt_state = cfg_pu_order ? ST_REFS : ST_READY;
               done_set  = !cfg_pu_order;
            end
            ST_READY: if (req_valid) begin
               if (page_hit) begin
                  nxt_cmd = req_write ? CMD_WR : CMD_RD;
                  nxt_ba  = rq_bank;
                  nxt_a[COL_W-1:0] = rq_col;
                  nxt_ack = 1'b1;
                  t_load  = 1'b1;
                  t_val   = CNT_W'(1);
               end else if (open_valid) begin
                  nxt_cmd   = CMD_PRE;
                  nxt_a[10] = 1'b1;
                  pre_fire  = 1'b1;
                  t_load    = 1'b1;
                  t_val     = CNT_W'(T_RP);
                  nxt_state = ST_ACT;
               end else begin
                  nxt_cmd   = CMD_ACT;
                  nxt_ba    = rq_bank;
                  nxt_a     = rq_row;
                  act_fire  = 1'b1;
                  t_load    = 1'b1;
                  t_val     = CNT_W'(T_RCD);
                  nxt_state = ST_COLUMN;
               end
            end
            ST_ACT: begin
               nxt_cmd   = CMD_ACT;
               nxt_ba    = rq_bank;
               nxt_a     = rq_row;
               act_fire  = 1'b1;
               t_load    = 1'b1;
               t_val     = CNT_W'(T_RCD);
               nxt_state = ST_COLUMN;
            end
            ST_COLUMN: begin
               nxt_cmd = req_write ? CMD_WR : CMD_RD;
               nxt_ba  = rq_bank;
               nxt_a[COL_W-1:0] = rq_col;
               nxt_ack = 1'b1;
               t_load  = 1'b1;
               t_val   = CNT_W'(1);
               nxt_state = ST_READY;
            end
            default: nxt_state = ST_COLD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_COLD;
         cmd_q   <= CMD_NOP;
         ba_q    <= '0;
         a_q     <= '0;
         ack_q   <= 1'b0;
         pu_done <= 1'b0;
         ref_cnt <= '0;
      end else begin
         state   <= nxt_state;
         cmd_q   <= nxt_cmd;
         ba_q    <= nxt_ba;
         a_q     <= nxt_a;
         ack_q   <= nxt_ack;
         if (done_set) pu_done <= 1'b1;
         if (ref_clr)      ref_cnt <= '0;
         else if (ref_inc) ref_cnt <= ref_cnt + 1'b1;
      end
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
   assign sd_ba     = ba_q;
   assign sd_a      = a_q;
   assign req_ack   = ack_q;
   assign init_done = pu_done;

   // acknowledge only travels with a column command
   p_ack_with_column_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> (cmd_q == CMD_RD || cmd_q == CMD_WR));
   p_column_a10_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> !a_q[10]);
   p_ack_after_init_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> init_done);
   p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init_done) |-> init_done);
   p_mode_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_LMR) |-> (a_q[3:0] == 4'b0 && (a_q >> 7) == '0 && ba_q == '0));
   p_lmr_quiet1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_q) == CMD_LMR) |-> (cmd_q == CMD_NOP));
   p_lmr_quiet2_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_q, 2) == CMD_LMR) |-> (cmd_q == CMD_NOP));
   p_cold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_done && !$past(cfg_pu_arm) && $past(state) == ST_COLD) |-> (cmd_q == CMD_NOP));
endmodule

// File: tb/sdram_cmd_seq_test.sv
`timescale 1ns/1ps
module sdram_cmd_seq_test;
   import sdseq_pkg::*;

   localparam int BA_W = 2, ROW_W = 13, COL_W = 9;
   localparam int T_RP = 2, T_RFC = 6, T_RCD = 2, N_REF = 8;
   localparam int AW = BA_W + ROW_W + COL_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_pu_arm = 1'b0, cfg_pu_order = 1'b0;
   logic [2:0] cfg_cas_lat = 3'd0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic req_ack, init_done, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [BA_W-1:0] sd_ba;
   logic [ROW_W-1:0] sd_a;

   always #5 clk = ~clk;

   sdram_cmd_seq #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .T_RP(T_RP),
                   .T_RFC(T_RFC), .T_RCD(T_RCD), .N_REF(N_REF)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_pu_arm(cfg_pu_arm), .cfg_pu_order(cfg_pu_order),
      .cfg_cas_lat(cfg_cas_lat), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_ack(req_ack), .init_done(init_done),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_ba(sd_ba), .sd_a(sd_a));

   typedef struct {
      logic [3:0]       cmd;
      logic [BA_W-1:0]  ba;
      logic [ROW_W-1:0] a;
      int               gap;
      string            tag;
   } exp_t;

   exp_t exp_q[$];
   int n_vec = 0, n_bad = 0;
   int nop_run = 0;
   int cycles = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic expect_cmd(input logic [3:0] c, input int b, input int a,
                             input int gap, input string tag);
      exp_t e;
      e.cmd = c; e.ba = BA_W'(b); e.a = ROW_W'(a); e.gap = gap; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compares every non-NOP command against the scoreboard
   always @(negedge clk) begin
      logic [3:0] c;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (!rst_n) nop_run = 0;
      else begin
         if (req_ack && !(c == CMD_RD || c == CMD_WR))
            check(0, "R7 ack without column", c, CMD_RD);
         if (c != CMD_NOP) begin
            if (exp_q.size() == 0) check(0, "R2 unexpected command", c, CMD_NOP);
            else begin
               exp_t e;
               e = exp_q.pop_front();
               check(c == e.cmd, {e.tag, " cmd"}, c, e.cmd);
               check(sd_ba == e.ba, {e.tag, " bank"}, sd_ba, e.ba);
               check(sd_a == e.a, {e.tag, " addr"}, sd_a, e.a);
               if (e.gap >= 0) check(nop_run == e.gap, {e.tag, " gap"}, nop_run, e.gap);
               if (c == CMD_RD || c == CMD_WR)
                  check(req_ack == 1'b1, {e.tag, " R7 ack"}, req_ack, 1);
            end
            nop_run = 0;
         end else nop_run++;
      end
   end

   task automatic access(input bit wr, input int b, input int r, input int col);
      @(negedge clk);
      req_write = wr;
      req_addr  = {BA_W'(b), ROW_W'(r), COL_W'(col)};
      req_valid = 1'b1;
      do @(negedge clk); while (!req_ack);
      req_valid = 1'b0;
   endtask

   task automatic settle(input string tag);
      repeat (12) @(negedge clk);
      check(exp_q.size() == 0, {tag, " all expected commands seen"}, exp_q.size(), 0);
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP, "R1 reset cmd",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, CMD_NOP);
      check(req_ack == 0 && init_done == 0, "R1 reset ack/done", {req_ack, init_done}, 0);
      rst_n = 1'b1;
   endtask

   task automatic powerup_order0;
      expect_cmd(CMD_PRE, 0, 1 << 10, -1, "R3 prea");
      for (int i = 0; i < N_REF; i++)
         expect_cmd(CMD_REF, 0, 0, (i == 0) ? T_RP : T_RFC, "R3 refresh");
      expect_cmd(CMD_LMR, 0, int'(cfg_cas_lat) << 4, T_RFC, "R5 mode load");
   endtask

   task automatic powerup_order1;
      expect_cmd(CMD_PRE, 0, 1 << 10, -1, "R4 prea");
      expect_cmd(CMD_LMR, 0, int'(cfg_cas_lat) << 4, T_RP, "R5 mode load");
      for (int i = 0; i < N_REF; i++)
         expect_cmd(CMD_REF, 0, 0, (i == 0) ? 2 : T_RFC, (i == 0) ? "R6 refresh after lmr" : "R4 refresh");
   endtask

   initial begin
      do_reset();
      // R2: request without arming must not start anything
      @(negedge clk);
      req_addr = '0; req_valid = 1'b1;
      repeat (20) @(negedge clk);
      check(req_ack == 0 && init_done == 0, "R2 idle while unarmed", {req_ack, init_done}, 0);
      check(exp_q.size() == 0, "R2 no command while unarmed", exp_q.size(), 0);
      req_valid = 1'b0;

      // order 0, CAS 3
      cfg_cas_lat = 3'd3; cfg_pu_order = 1'b0;
      powerup_order0();
      expect_cmd(CMD_ACT, 1, 100, 2, "R6 activate after lmr");
      expect_cmd(CMD_RD, 1, 5, T_RCD, "R9 first read");
      check(init_done == 0, "R10 not done before start", init_done, 0);
      cfg_pu_arm = 1'b1;
      access(0, 1, 100, 5);
      check(init_done == 1, "R10 done after walk", init_done, 1);
      // hit
      expect_cmd(CMD_WR, 1, 9'h1ff, -1, "R9 page hit write");
      access(1, 1, 100, 9'h1ff);
      @(negedge clk);
      check(req_ack == 0, "R7 ack single cycle", req_ack, 0);
      // miss: same bank other row
      expect_cmd(CMD_PRE, 0, 1 << 10, -1, "R8 precharge");
      expect_cmd(CMD_ACT, 1, 13'h1abc, T_RP, "R8 activate");
      expect_cmd(CMD_WR, 1, 7, T_RCD, "R8 write");
      access(1, 1, 13'h1abc, 7);
      // miss: other bank same row
      expect_cmd(CMD_PRE, 0, 1 << 10, -1, "R8 precharge bank change");
      expect_cmd(CMD_ACT, 3, 13'h1abc, T_RP, "R8 activate bank change");
      expect_cmd(CMD_RD, 3, 0, T_RCD, "R8 read bank change");
      access(0, 3, 13'h1abc, 0);
      settle("R8");
      check(init_done == 1, "R10 done sticky", init_done, 1);

      // order 1, CAS 2
      cfg_pu_arm = 1'b0;
      do_reset();
      cfg_cas_lat = 3'd2; cfg_pu_order = 1'b1; cfg_pu_arm = 1'b1;
      powerup_order1();
      expect_cmd(CMD_ACT, 0, 13'h0fff, T_RFC, "R9 activate after walk");
      expect_cmd(CMD_WR, 0, 9'h0aa, T_RCD, "R9 write after walk");
      access(1, 0, 13'h0fff, 9'h0aa);
      expect_cmd(CMD_RD, 0, 9'h055, -1, "R9 page hit read");
      access(0, 0, 13'h0fff, 9'h055);
      settle("R4");

      // order 0 again with CAS 7 (all mode-field bits)
      do_reset();
      cfg_cas_lat = 3'd7; cfg_pu_order = 1'b0;
      powerup_order0();
      expect_cmd(CMD_ACT, 2, 1, 2, "R6 activate after lmr");
      expect_cmd(CMD_RD, 2, 1, T_RCD, "R9 read");
      access(0, 2, 1, 1);
      settle("R5");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule